// File: doc/BRIEF.md
# Selectable-Mode Pin Capture Bank

This block sits between a byte of external input pins and the input bus of on-chip logic. Each bit has its own mode. In pass mode the pin goes straight through. In latch mode the bit is transparent while its gate is high and keeps its value while the gate is low. In register mode the bit takes the pin value once, when its source goes from low to high. The bits are split into 4-bit groups. Each group has a single gate/clock source, and a per-group select picks that source: either the group's own control term or the shared address strobe. Selecting the strobe lets the bank catch address bits that are only valid around the strobe pulse, such as the bits above a 16-bit address, and hold them for the logic array. A processor reads the same byte through a gated read port.

The block runs on one system clock. Each group has a two-state tracker for its selected source. In `SRC_LOW`, seeing the source high fires a capture and moves the tracker to `SRC_HIGH`. In `SRC_HIGH`, seeing the source low moves it back to `SRC_LOW`. Any other combination leaves the state unchanged. Each bit has one storage flop. It loads from the pin on a clock edge where either the bit is in latch mode with its gate high, or the bit is in register mode and its group fires.

Top module: `pin_capture_bank`

## Requirements
- R1: With mode code 00 (pass), `bus_out[i]` equals `pin_in[i]` without waiting for a clock edge.
- R2: With mode code 01 (latch), `bus_out[i]` follows `pin_in[i]` while the group's selected source is high. While it is low, the bit shows the pin value taken at the last clock edge where the source was high.
- R3: With mode code 10 (register), a bit loads the pin value at the first clock edge where its selected source is seen high after being seen low. At every other edge it keeps its value.
- R4: A source that stays high causes only one register-mode capture. A new capture needs the source to be seen low first.
- R5: `src_sel[g]` = 0 makes the group use `group_term[g]`; `src_sel[g]` = 1 makes it use `addr_strobe`. Group 0 covers bits 3..0 and group 1 covers bits 7..4. A source that is not selected has no effect on its group.
- R6: Active-low `rst_n` clears every storage bit to zero and returns each tracker to `SRC_LOW`. If the selected source is high at the first edge after release, that edge fires.
- R7: Mode code 11 behaves the same as pass mode.
- R8: `rd_data` equals `bus_out` when `rd_sel` and `rd_stb` are both 1. Otherwise it is all zeros.
- R9: The latch and register modes of a bit share one storage flop, so a mode change keeps the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 8 | External pin values |
| group_term | input | 2 | Per-group control term; bit g drives group g |
| addr_strobe | input | 1 | Shared address strobe |
| mode_cfg | input | 16 | Two mode bits per pin; bits [2i+1:2i] set pin i |
| src_sel | input | 2 | Per-group source select: 0 = term, 1 = strobe |
| bus_out | output | 8 | Values sent to the logic input bus |
| rd_sel | input | 1 | Processor read select |
| rd_stb | input | 1 | Processor read strobe |
| rd_data | output | 8 | Processor read data; zero when not selected |

## Verification
The assertions assume that the terms, the strobe, the pins and the configuration are synchronous to `clk` and hold steady around each rising edge. They also assume that a source pulse lasts at least one clock so that the tracker can see it. The bench changes every input only on the falling edge and keeps each source level for at least one full cycle. This means a pulse that fits between two edges never occurs. The bench also makes mode changes between steps, so each hold property compares cycles that share one mode.

// File: rtl/pin_capture_pkg.sv
package pin_capture_pkg;

    typedef enum logic [1:0] {
        MODE_PASS  = 2'b00,
        MODE_LATCH = 2'b01,
        MODE_REG   = 2'b10,
        MODE_RSVD  = 2'b11
    } cell_mode_t;

    typedef enum logic {
        SRC_LOW  = 1'b0,
        SRC_HIGH = 1'b1
    } src_state_t;

endpackage

// File: rtl/capture_src.sv
module capture_src
    import pin_capture_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic term,
    input  logic strobe,
    input  logic use_strobe,
    output logic gate,
    output logic fire
);

    src_state_t state_q, state_d;
    logic       level;

    assign level = use_strobe ? strobe : term;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SRC_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        gate    = level;
        unique case (state_q)
            SRC_LOW: begin
                if (level) begin
                    fire    = 1'b1;
                    state_d = SRC_HIGH;
                end
            end
            SRC_HIGH: begin
                if (!level) state_d = SRC_LOW;
            end
        endcase
    end

    // R4: a capture is never followed by another in the next cycle
    p_single_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

endmodule

// File: rtl/capture_cell.sv
module capture_cell
    import pin_capture_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cell_mode_t mode,
    input  logic       pin,
    input  logic       gate,
    input  logic       fire,
    output logic       q
);

    logic store_q;
    logic load;

    assign load = ((mode == MODE_LATCH) && gate) || ((mode == MODE_REG) && fire);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    store_q <= 1'b0;
        else if (load) store_q <= pin;
    end

    always_comb begin
        unique case (mode)
            MODE_PASS,
            MODE_RSVD:  q = pin;
            MODE_LATCH: q = gate ? pin : store_q;
            MODE_REG:   q = store_q;
        endcase
    end

    // R2: closed latch keeps its value
    p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LATCH && !gate && $past(mode) == MODE_LATCH && !$past(gate))
        |-> $stable(q));

    // R3: register bit changes only after a capture
    p_reg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_REG && $past(mode) == MODE_REG && !$past(fire))
        |-> $stable(q));

    // R6: register bit reads zero on the first edge after reset
    p_reset_clear_r6: assert property (@(posedge clk)
        ($rose(rst_n) && mode == MODE_REG) |-> (q == 1'b0));

endmodule

// File: rtl/pin_capture_bank.sv
module pin_capture_bank
    import pin_capture_pkg::*;
#(
    parameter int GROUP_W    = 4,
    parameter int NUM_GROUPS = 2,
    localparam int WIDTH     = GROUP_W * NUM_GROUPS,
    localparam int CFG_W     = 2 * WIDTH
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [WIDTH-1:0]      pin_in,
    input  logic [NUM_GROUPS-1:0] group_term,
    input  logic                  addr_strobe,
    input  logic [CFG_W-1:0]      mode_cfg,
    input  logic [NUM_GROUPS-1:0] src_sel,
    output logic [WIDTH-1:0]      bus_out,
    input  logic                  rd_sel,
    input  logic                  rd_stb,
    output logic [WIDTH-1:0]      rd_data
);

    logic [NUM_GROUPS-1:0] grp_gate;
    logic [NUM_GROUPS-1:0] grp_fire;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        capture_src u_src (
            .clk        (clk),
            .rst_n      (rst_n),
            .term       (group_term[g]),
            .strobe     (addr_strobe),
            .use_strobe (src_sel[g]),
            .gate       (grp_gate[g]),
            .fire       (grp_fire[g])
        );

        for (genvar b = 0; b < GROUP_W; b++) begin : g_bit
            localparam int IDX = g * GROUP_W + b;
            capture_cell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .mode  (cell_mode_t'(mode_cfg[2*IDX +: 2])),
                .pin   (pin_in[IDX]),
                .gate  (grp_gate[g]),
                .fire  (grp_fire[g]),
                .q     (bus_out[IDX])
            );
        end
    end

    // R8: read buffer gated by select and strobe
    assign rd_data = (rd_sel && rd_stb) ? bus_out : '0;

endmodule

// File: tb/pin_capture_bank_tb.sv
module pin_capture_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_in = '0;
    logic [1:0]  group_term = '0;
    logic        addr_strobe = 1'b0;
    logic [15:0] mode_cfg = '0;
    logic [1:0]  src_sel = '0;
    logic        rd_sel = 1'b0;
    logic        rd_stb = 1'b0;
    logic [7:0]  bus_out;
    logic [7:0]  rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pin_capture_bank u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_in      (pin_in),
        .group_term  (group_term),
        .addr_strobe (addr_strobe),
        .mode_cfg    (mode_cfg),
        .src_sel     (src_sel),
        .bus_out     (bus_out),
        .rd_sel      (rd_sel),
        .rd_stb      (rd_stb),
        .rd_data     (rd_data)
    );

    // {mode[15:0], sel[1:0], pin[7:0], term0, term1, strobe, expected[7:0]}
    localparam int NV = 15;
    localparam logic [36:0] VEC [NV] = '{
        {16'h0000, 2'b00, 8'hA5, 1'b0, 1'b0, 1'b0, 8'hA5}, // R1 pass
        {16'h5555, 2'b00, 8'h3C, 1'b1, 1'b1, 1'b0, 8'h3C}, // R2 open
        {16'h5555, 2'b00, 8'hC3, 1'b0, 1'b1, 1'b0, 8'hCC}, // R2 low closed
        {16'h5555, 2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 8'hCC}, // R2 both closed
        {16'h5555, 2'b01, 8'h5A, 1'b0, 1'b0, 1'b1, 8'hCA}, // R5 low on strobe
        {16'h5555, 2'b01, 8'hFF, 1'b1, 1'b0, 1'b0, 8'hCA}, // R5 term ignored
        {16'hAAAA, 2'b00, 8'h12, 1'b0, 1'b0, 1'b0, 8'hCA}, // R9 kept store
        {16'hAAAA, 2'b00, 8'h34, 1'b1, 1'b0, 1'b0, 8'hC4}, // R3 low fires
        {16'hAAAA, 2'b00, 8'h56, 1'b1, 1'b1, 1'b0, 8'h54}, // R4 low stays
        {16'hAAAA, 2'b00, 8'h78, 1'b0, 1'b1, 1'b0, 8'h54}, // R4 high stays
        {16'hAAAA, 2'b00, 8'h9B, 1'b1, 1'b0, 1'b0, 8'h5B}, // R3 refire
        {16'hAAAA, 2'b11, 8'hE1, 1'b0, 1'b0, 1'b1, 8'hEB}, // R5 switch
        {16'hAAAA, 2'b11, 8'h77, 1'b0, 1'b0, 1'b0, 8'hEB}, // R3 hold
        {16'hAAAA, 2'b11, 8'h26, 1'b0, 1'b0, 1'b1, 8'h26}, // R5 both strobe
        {16'h3600, 2'b00, 8'hC0, 1'b0, 1'b0, 1'b0, 8'hE0}  // R7 mixed
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        mode_cfg = 16'hAAAA;
        #1;
        check("R6 reset", bus_out, 8'h00);
        check("R8 idle read", rd_data, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            mode_cfg      = VEC[i][36:21];
            src_sel       = VEC[i][20:19];
            pin_in        = VEC[i][18:11];
            group_term[0] = VEC[i][10];
            group_term[1] = VEC[i][9];
            addr_strobe   = VEC[i][8];
            @(posedge clk);
            #1;
            check($sformatf("R1-7 vec%0d", i), bus_out, VEC[i][7:0]);
        end

        // R1: pass mode follows pin with no edge
        @(negedge clk);
        mode_cfg = 16'h0000;
        pin_in   = 8'h69;
        #0.5;
        check("R1 comb", bus_out, 8'h69);
        // R7: reserved code behaves as pass
        mode_cfg = 16'hFFFF;
        pin_in   = 8'h96;
        #0.5;
        check("R7 rsvd", bus_out, 8'h96);

        // R8: read gating
        rd_sel = 1'b1; rd_stb = 1'b0; #0.5;
        check("R8 stb low", rd_data, 8'h00);
        rd_sel = 1'b0; rd_stb = 1'b1; #0.5;
        check("R8 sel low", rd_data, 8'h00);
        rd_sel = 1'b1; #0.5;
        check("R8 read", rd_data, 8'h96);
        rd_sel = 1'b0; rd_stb = 1'b0;

        // R6: reset clears stores; high source at release fires once
        @(negedge clk);
        mode_cfg   = 16'hAAAA;
        src_sel    = 2'b00;
        group_term = 2'b01;
        addr_strobe = 1'b0;
        pin_in     = 8'h0F;
        rst_n      = 1'b0;
        #0.5;
        check("R6 clear", bus_out, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R6 fire after release", bus_out, 8'h0F);
        @(negedge clk);
        pin_in = 8'hF0;
        @(posedge clk);
        #1;
        check("R4 no refire", bus_out, 8'h0F);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule